// File: doc/BRIEF.md
# Pixel Threshold Classifier with Histogram and Peak Capture

This block sits in a streaming pixel pipeline and reduces the range of each pixel against five programmable thresholds. One pixel enters per clock. Depending on the selected mode, the block does one of three things to the value:

- it limits the value to the outer threshold pair;
- it raises the value to the nearest threshold at or above it;
- it turns the value into a three-level hysteresis code that remembers whether the previous pixel on the line was strong.

In every mode, the block also counts how many pixels land in each of the four intervals between neighbouring thresholds, and it tracks the largest raw pixel value of the frame. A frame-start strobe clears these statistics. A frame-end strobe copies them to status outputs, which stay steady for the whole of the next frame.

Thresholds and mode are written through a small write port. Writes apply to every pixel accepted after the write edge, so the thresholds can change while the stream is running.

Top module: `pix_range_stat`

## Requirements
- R1: An accepted pixel (`in_valid` high at a clock edge) produces `out_valid` high exactly two clock edges later. `out_valid` is low in every cycle that does not correspond to an accepted pixel. One pixel can be accepted on every clock.
- R2: In limit mode (mode code 0), `out_pix` is `in_pix` raised to at least T0 and lowered to at most T4. Mode code 3 behaves exactly like mode code 0.
- R3: In round-up mode (mode code 1), `out_pix` is the smallest threshold Tk with Tk >= `in_pix`. A pixel above T4 gives T4.
- R4: In hysteresis mode (mode code 2), the output is as follows:
  - a pixel >= T3 gives 2;
  - a pixel < T1 gives 0;
  - any other pixel gives 1 if the previous accepted pixel on the same line was >= T3, and 0 otherwise.
  A pixel with `in_sol` high, or the first pixel after `frame_start`, treats the previous pixel as not strong.
- R5: A write with `cfg_we` high updates a register chosen by `cfg_addr`:
  - addresses 0 to 4 hold thresholds T0 to T4;
  - address 5 holds the mode code in `cfg_wdata[1:0]`.
  The new value applies from the next accepted pixel onward.
- R6: Histogram bin k (k = 0..3) counts accepted pixels v with Tk <= v < Tk+1. Pixels below T0, or at or above T4, are counted in no bin. Bin k is reported in `stat_bins[k*CNT_W +: CNT_W]`.
- R7: A bin counter stops at 2^CNT_W - 1 and never wraps.
- R8: The block tracks the largest raw `in_pix` accepted since the last `frame_start`.
- R9: `frame_start` clears the bin counters and the running maximum. `frame_end` copies them to `stat_bins` and `stat_max`, visible after that edge. The status outputs change at no other time. `frame_end` must come at least two clocks after the last pixel of the frame.
- R10: After reset the block is in the following state:
  - `out_valid`, `stat_bins` and `stat_max` are 0;
  - the mode is 0;
  - Tk = k * 2^(PIX_W-2) for k < 4, and T4 is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select: 0-4 thresholds, 5 mode |
| cfg_wdata | input | PIX_W | Register write data |
| frame_start | input | 1 | Clears statistics and hysteresis history |
| frame_end | input | 1 | Copies statistics to status outputs |
| in_valid | input | 1 | Input pixel valid |
| in_sol | input | 1 | Input pixel is first on its line |
| in_pix | input | PIX_W | Input pixel value |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | PIX_W | Mode-processed pixel |
| stat_bins | output | 4*CNT_W | Captured bin counts, bin k at bits k*CNT_W upward |
| stat_max | output | PIX_W | Captured frame maximum |

## Verification
The bench builds the block with an 8-bit pixel and 4-bit bin counters. With these values, a frame of twenty pixels is enough to push one bin to its ceiling of 15, so the no-wrap rule can be observed in a short run. Because the pixel is 8 bits wide, the default thresholds 0, 64, 128, 192 and 255 can be checked through the round-up mode. The threshold set used in most tests (10, 50, 100, 150, 200) leaves room on both sides of each threshold, so clipping, rounding, every bin edge and all three hysteresis branches can be reached with hand-picked pixel values.

// File: rtl/prs_pkg.sv
package prs_pkg;
    localparam int NUM_THR = 5;
    localparam int NUM_BIN = NUM_THR - 1;
    localparam int ADDR_W  = 3;
    localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd5;
    // hysteresis uses T1 as its low and T3 as its high threshold
    localparam int HYS_LO = 1;
    localparam int HYS_HI = 3;

    typedef enum logic [1:0] {
        MODE_CLIP  = 2'd0,
        MODE_QUANT = 2'd1,
        MODE_HYST  = 2'd2,
        MODE_ALT   = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        HC_WEAK   = 2'd0,
        HC_MID    = 2'd1,
        HC_STRONG = 2'd2
    } hclass_e;
endpackage

// File: rtl/prs_cfg.sv
module prs_cfg
    import prs_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            we,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [PIX_W-1:0]                wdata,
    output logic [NUM_THR-1:0][PIX_W-1:0]   thr,
    output mode_e                           mode
);
    function automatic logic [PIX_W-1:0] thr_default(int k);
        if (k >= NUM_BIN) return '1;
        return PIX_W'(k) << (PIX_W - 2);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NUM_THR; k++) thr[k] <= thr_default(k);
            mode <= MODE_CLIP;
        end else if (we) begin
            if (int'(addr) < NUM_THR) thr[addr] <= wdata;
            else if (addr == ADDR_MODE) mode <= mode_e'(wdata[1:0]);
        end
    end
endmodule

// File: rtl/prs_classify.sv
module prs_classify
    import prs_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            in_valid,
    input  logic                            in_sol,
    input  logic [PIX_W-1:0]                in_pix,
    input  logic [NUM_THR-1:0][PIX_W-1:0]   thr,
    input  mode_e                           mode,
    output logic                            s1_valid,
    output logic                            s1_sol,
    output mode_e                           s1_mode,
    output logic [PIX_W-1:0]                s1_pix,
    output logic [PIX_W-1:0]                s1_clip,
    output logic [PIX_W-1:0]                s1_quant,
    output hclass_e                         s1_hcls,
    output logic [NUM_BIN-1:0]              s1_hit
);
    logic [PIX_W-1:0]   clip_c, quant_c;
    hclass_e            hcls_c;
    logic [NUM_BIN-1:0] hit_c;

    always_comb begin
        clip_c = in_pix;
        if (in_pix < thr[0]) clip_c = thr[0];
        else if (in_pix > thr[NUM_THR-1]) clip_c = thr[NUM_THR-1];

        // scan downward so the lowest qualifying threshold wins
        quant_c = thr[NUM_THR-1];
        for (int k = NUM_THR - 1; k >= 0; k--)
            if (in_pix <= thr[k]) quant_c = thr[k];

        if (in_pix >= thr[HYS_HI])     hcls_c = HC_STRONG;
        else if (in_pix < thr[HYS_LO]) hcls_c = HC_WEAK;
        else                           hcls_c = HC_MID;
    end

    for (genvar b = 0; b < NUM_BIN; b++) begin : g_bin
        assign hit_c[b] = (in_pix >= thr[b]) && (in_pix < thr[b+1]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_sol   <= 1'b0;
            s1_mode  <= MODE_CLIP;
            s1_pix   <= '0;
            s1_clip  <= '0;
            s1_quant <= '0;
            s1_hcls  <= HC_WEAK;
            s1_hit   <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_sol   <= in_sol;
                s1_mode  <= mode;
                s1_pix   <= in_pix;
                s1_clip  <= clip_c;
                s1_quant <= quant_c;
                s1_hcls  <= hcls_c;
                s1_hit   <= hit_c;
            end
        end
    end
endmodule

// File: rtl/prs_select.sv
module prs_select
    import prs_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic             s1_valid,
    input  logic             s1_sol,
    input  mode_e            s1_mode,
    input  logic [PIX_W-1:0] s1_clip,
    input  logic [PIX_W-1:0] s1_quant,
    input  hclass_e          s1_hcls,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix
);
    logic             prev_strong;
    logic             prev_eff;
    logic [1:0]       hyst_code;
    logic [PIX_W-1:0] sel_pix;

    always_comb begin
        prev_eff = prev_strong && !s1_sol;
        case (s1_hcls)
            HC_STRONG: hyst_code = 2'd2;
            HC_MID:    hyst_code = prev_eff ? 2'd1 : 2'd0;
            default:   hyst_code = 2'd0;
        endcase
        case (s1_mode)
            MODE_QUANT: sel_pix = s1_quant;
            MODE_HYST:  sel_pix = PIX_W'(hyst_code);
            default:    sel_pix = s1_clip;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_pix     <= '0;
            prev_strong <= 1'b0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) out_pix <= sel_pix;
            if (frame_start)   prev_strong <= 1'b0;
            else if (s1_valid) prev_strong <= (s1_hcls == HC_STRONG);
        end
    end
endmodule

// File: rtl/prs_hist.sv
module prs_hist
    import prs_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int CNT_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       frame_start,
    input  logic                       frame_end,
    input  logic                       s1_valid,
    input  logic [PIX_W-1:0]           s1_pix,
    input  logic [NUM_BIN-1:0]         s1_hit,
    output logic [NUM_BIN*CNT_W-1:0]   stat_bins,
    output logic [PIX_W-1:0]           stat_max
);
    logic [NUM_BIN-1:0][CNT_W-1:0] cnt;
    logic [PIX_W-1:0]              run_max;

    always_ff @(posedge clk) begin
        if (rst || frame_start) begin
            cnt     <= '0;
            run_max <= '0;
        end else if (s1_valid) begin
            for (int b = 0; b < NUM_BIN; b++)
                if (s1_hit[b] && (cnt[b] != '1)) cnt[b] <= cnt[b] + 1'b1;
            if (s1_pix > run_max) run_max <= s1_pix;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_bins <= '0;
            stat_max  <= '0;
        end else if (frame_end) begin
            stat_bins <= cnt;
            stat_max  <= run_max;
        end
    end
endmodule

// File: rtl/pix_range_stat.sv
module pix_range_stat
    import prs_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int CNT_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic [2:0]               cfg_addr,
    input  logic [PIX_W-1:0]         cfg_wdata,
    input  logic                     frame_start,
    input  logic                     frame_end,
    input  logic                     in_valid,
    input  logic                     in_sol,
    input  logic [PIX_W-1:0]         in_pix,
    output logic                     out_valid,
    output logic [PIX_W-1:0]         out_pix,
    output logic [4*CNT_W-1:0]       stat_bins,
    output logic [PIX_W-1:0]         stat_max
);
    logic [NUM_THR-1:0][PIX_W-1:0] thr_q;
    mode_e                         mode_q;
    logic                          s1_valid, s1_sol;
    mode_e                         s1_mode;
    logic [PIX_W-1:0]              s1_pix, s1_clip, s1_quant;
    hclass_e                       s1_hcls;
    logic [NUM_BIN-1:0]            s1_hit;

    prs_cfg #(.PIX_W(PIX_W)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .thr(thr_q), .mode(mode_q)
    );

    prs_classify #(.PIX_W(PIX_W)) u_cls (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sol(in_sol), .in_pix(in_pix),
        .thr(thr_q), .mode(mode_q),
        .s1_valid(s1_valid), .s1_sol(s1_sol), .s1_mode(s1_mode), .s1_pix(s1_pix),
        .s1_clip(s1_clip), .s1_quant(s1_quant), .s1_hcls(s1_hcls), .s1_hit(s1_hit)
    );

    prs_select #(.PIX_W(PIX_W)) u_sel (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .s1_valid(s1_valid), .s1_sol(s1_sol), .s1_mode(s1_mode),
        .s1_clip(s1_clip), .s1_quant(s1_quant), .s1_hcls(s1_hcls),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    prs_hist #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_hist (
        .clk(clk), .rst(rst), .frame_start(frame_start), .frame_end(frame_end),
        .s1_valid(s1_valid), .s1_pix(s1_pix), .s1_hit(s1_hit),
        .stat_bins(stat_bins), .stat_max(stat_max)
    );
endmodule

// File: rtl/prs_sva.sv
module prs_sva
    import prs_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int CNT_W = 16
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            cfg_we,
    input logic                            frame_start,
    input logic                            frame_end,
    input logic                            in_valid,
    input logic                            out_valid,
    input logic [PIX_W-1:0]                out_pix,
    input logic [4*CNT_W-1:0]              stat_bins,
    input logic [PIX_W-1:0]                stat_max,
    input mode_e                           mode,
    input logic [NUM_THR-1:0][PIX_W-1:0]   thr,
    input logic [NUM_BIN-1:0][CNT_W-1:0]   bin_cnt,
    input logic [PIX_W-1:0]                run_max
);
    a_r1_valid_lat: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 out_valid);

    a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ##1 !out_valid);

    a_r2_clip_range: assert property (@(posedge clk) disable iff (rst)
        (out_valid && mode == MODE_CLIP && thr[0] <= thr[NUM_THR-1]
         && !$past(cfg_we) && !$past(cfg_we, 2))
        |-> (out_pix >= thr[0] && out_pix <= thr[NUM_THR-1]));

    a_r4_hyst_codes: assert property (@(posedge clk) disable iff (rst)
        (out_valid && mode == MODE_HYST && !$past(cfg_we) && !$past(cfg_we, 2))
        |-> out_pix <= PIX_W'(2));

    a_r9_stat_hold: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> ($stable(stat_bins) && $stable(stat_max)));

    a_r8_max_mono: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> run_max >= $past(run_max));

    for (genvar b = 0; b < NUM_BIN; b++) begin : g_sat
        a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
            (bin_cnt[b] == '1 && !frame_start) |=> bin_cnt[b] == '1);
    end
endmodule

bind pix_range_stat prs_sva #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_sva (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .frame_start(frame_start),
    .frame_end(frame_end), .in_valid(in_valid), .out_valid(out_valid),
    .out_pix(out_pix), .stat_bins(stat_bins), .stat_max(stat_max),
    .mode(mode_q), .thr(thr_q), .bin_cnt(u_hist.cnt), .run_max(u_hist.run_max)
);

// File: tb/pix_range_stat_tb_top.sv
module pix_range_stat_tb_top;
    localparam int PW   = 8;
    localparam int CW   = 4;
    localparam int MAXC = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [PW-1:0] cfg_wdata = '0;
    logic          frame_start = 1'b0, frame_end = 1'b0;
    logic          in_valid = 1'b0, in_sol = 1'b0;
    logic [PW-1:0] in_pix = '0;
    logic          out_valid;
    logic [PW-1:0] out_pix;
    logic [4*CW-1:0] stat_bins;
    logic [PW-1:0] stat_max;

    pix_range_stat #(.PIX_W(PW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_start(frame_start), .frame_end(frame_end),
        .in_valid(in_valid), .in_sol(in_sol), .in_pix(in_pix),
        .out_valid(out_valid), .out_pix(out_pix),
        .stat_bins(stat_bins), .stat_max(stat_max)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    int th[5];
    int cur_mode = 0;
    int stim[32];
    bit sol_s[32];
    int n_stim = 0;
    int got[$];

    always @(negedge clk) if (!rst && out_valid) got.push_back(int'(out_pix));

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = PW'(d);
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < 5) th[a] = d; else cur_mode = d & 3;
    endtask

    task automatic set_thr(input int a, input int b, input int c, input int d, input int e);
        cfg_write(0, a); cfg_write(1, b); cfg_write(2, c); cfg_write(3, d); cfg_write(4, e);
    endtask

    task automatic pulse_fs();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
    endtask

    task automatic pulse_fe();
        @(negedge clk); frame_end = 1'b1;
        @(negedge clk); frame_end = 1'b0;
    endtask

    task automatic add(input int p, input bit s);
        stim[n_stim] = p; sol_s[n_stim] = s; n_stim++;
    endtask

    task automatic stream();
        got.delete();
        for (int i = 0; i < n_stim; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_pix = PW'(stim[i]); in_sol = sol_s[i];
        end
        @(negedge clk);
        in_valid = 1'b0; in_sol = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    function automatic int model(input int m, input int p, input bit prev);
        int r;
        if (m == 1) begin
            r = th[4];
            for (int k = 4; k >= 0; k--) if (p <= th[k]) r = th[k];
        end else if (m == 2) begin
            if (p >= th[3]) r = 2;
            else if (p < th[1]) r = 0;
            else r = prev ? 1 : 0;
        end else begin
            r = p;
            if (p < th[0]) r = th[0];
            else if (p > th[4]) r = th[4];
        end
        return r;
    endfunction

    task automatic check_outputs(input string req);
        bit prev = 0;
        chk({req, " count"}, got.size(), n_stim);
        for (int i = 0; i < n_stim && i < got.size(); i++) begin
            if (sol_s[i]) prev = 0;
            chk(req, got[i], model(cur_mode, stim[i], prev));
            prev = (stim[i] >= th[3]);
        end
    endtask

    task automatic check_stats(input string req);
        int eb[4];
        int emax = 0;
        for (int b = 0; b < 4; b++) eb[b] = 0;
        for (int i = 0; i < n_stim; i++) begin
            if (stim[i] > emax) emax = stim[i];
            for (int b = 0; b < 4; b++)
                if (stim[i] >= th[b] && stim[i] < th[b+1] && eb[b] < MAXC) eb[b]++;
        end
        for (int b = 0; b < 4; b++)
            chk({req, " bin"}, int'(stat_bins[b*CW +: CW]), eb[b]);
        chk("R8 max", int'(stat_max), emax);
    endtask

    task automatic t_reset();
        chk("R10 out_valid", int'(out_valid), 0);
        chk("R10 stat_max", int'(stat_max), 0);
        chk("R10 stat_bins", int'(stat_bins), 0);
        th = '{0, 64, 128, 192, 255};
        n_stim = 0; add(77, 1); add(255, 0);
        stream();
        check_outputs("R10 default clip");
        cfg_write(5, 1);
        n_stim = 0; add(70, 1); add(0, 0); add(200, 0);
        stream();
        check_outputs("R10 default thresholds");
    endtask

    task automatic t_latency();
        got.delete();
        @(negedge clk); in_valid = 1'b1; in_pix = 8'd33;
        @(negedge clk); in_valid = 1'b0;
        chk("R1 early", int'(out_valid), 0);
        @(negedge clk);
        chk("R1 valid at 2", int'(out_valid), 1);
        @(negedge clk);
        chk("R1 single", int'(out_valid), 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_clip();
        cfg_write(5, 0);
        set_thr(10, 50, 100, 150, 200);
        n_stim = 0; add(5, 1); add(10, 0); add(77, 0); add(200, 0); add(250, 0); add(0, 0);
        stream();
        check_outputs("R2 clip");
        cfg_write(5, 3);
        cur_mode = 0;
        n_stim = 0; add(250, 1); add(3, 0); add(120, 0);
        stream();
        check_outputs("R2 mode3");
    endtask

    task automatic t_quant();
        cfg_write(5, 1);
        n_stim = 0;
        add(0, 1); add(10, 0); add(11, 0); add(100, 0); add(149, 0); add(201, 0); add(255, 0);
        stream();
        check_outputs("R3 round-up");
        cfg_write(2, 120);
        n_stim = 0; add(101, 1); add(121, 0);
        stream();
        check_outputs("R5 rewrite");
        cfg_write(2, 100);
    endtask

    task automatic t_hyst();
        cfg_write(5, 2);
        n_stim = 0;
        add(60, 1); add(160, 0); add(70, 0); add(80, 0); add(40, 0);
        add(150, 0); add(149, 0); add(100, 1); add(200, 0); add(120, 1);
        stream();
        check_outputs("R4 hysteresis");
    endtask

    task automatic t_hist();
        cfg_write(5, 0);
        pulse_fs();
        n_stim = 0; add(30, 1);
        stream();
        pulse_fe();
        check_stats("R6 single");
        pulse_fs();
        n_stim = 0;
        add(10, 1); add(49, 0); add(50, 0); add(100, 0); add(149, 0);
        add(150, 0); add(199, 0); add(200, 0); add(9, 0);
        stream();
        chk("R9 hold max", int'(stat_max), 30);
        chk("R9 hold bin0", int'(stat_bins[CW-1:0]), 1);
        pulse_fe();
        check_stats("R6 edges");
    endtask

    task automatic t_sat();
        pulse_fs();
        n_stim = 0;
        for (int i = 0; i < 20; i++) add(60, i == 0);
        stream();
        pulse_fe();
        check_stats("R7 saturate");
        chk("R7 ceiling", int'(stat_bins[CW +: CW]), MAXC);
        pulse_fs();
        n_stim = 0; add(120, 1);
        stream();
        pulse_fe();
        check_stats("R9 cleared");
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_latency();
        t_clip();
        t_quant();
        t_hyst();
        t_hist();
        t_sat();
        done = 1;
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
        end
    end
endmodule